// File: doc/BRIEF.md
# Activity monitor channel with watermark interrupts

This block watches one activity event source. Each incoming event pulse adds a programmable weight to a sample accumulator. A shared sampling period is counted in millisecond ticks. When the period ends, the channel closes the sample and folds it into an exponential moving average whose window is a power of two. It then clears the accumulator for the next period.

Two pairs of watermarks turn this activity into interrupts. The raw sample is tested against an upper and a lower bound, and a per-direction run counter raises an interrupt only after a programmable number of back-to-back breaching periods. The updated average has its own pair of bounds, and each bound raises its own interrupt. Status bits are cleared by writing ones to them. The interrupt line is the OR of the status bits that are both set and enabled, and it is held low while the channel is off. Software programs the channel through a word-addressed register port, and a policy agent reacts to the interrupt.

Top module: `act_mon`

## Requirements
- R1: Every register resets to zero. The configuration registers read back what was written: threshold hi 0x04, threshold lo 0x08, average hi 0x10, average lo 0x14, weight 0x18 and tick period 0x40. The control register at 0x00 keeps only its defined bits (mask 0xFFB41C00).
- R2: The period closes on the (P+1)-th millisecond tick, where P is the tick period register. This happens only while the channel enable (control bit 31) and the periodic enable (control bit 18) are both set. With bit 18 clear, ticks close no period.
- R3: Each event pulse adds the weight register to the accumulator, which saturates at all ones. An event in the cycle that closes a period counts toward the next period.
- R4: At each close the average becomes avg + ((sample − avg) >>> (K+1)). The shift is arithmetic and K is control bits 12:10.
- R5: A write to 0x0C seeds the average. Reads of both 0x0C and 0x20 return the current average.
- R6: Control bits 28:26 hold N−1. After N consecutive closes with sample > threshold hi, status bit 31 sets if control bit 30 is set. The run count restarts after it fires and after any close without that breach.
- R7: Control bits 25:23 hold N−1. After N consecutive closes with sample < threshold lo, status bit 30 sets if control bit 29 is set. The same restart rules apply.
- R8: At a close, status bit 29 sets when the updated average is greater than average hi and control bit 21 is set. Status bit 28 sets when the updated average is less than average lo and control bit 20 is set.
- R9: Writing to the status register at 0x24 clears exactly the status bits written as one. The other status bits are unchanged.
- R10: irq_o is high when control bit 31 is set and any of status bits 31/30/29/28 is set together with its enable, which is control bit 30/29/21/20 respectively.
- R11: While control bit 31 is clear, the accumulator, the run counts and the tick count are held at zero, and the status bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Byte address of the word register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| evt_i | input | 1 | One activity event per high cycle |
| ms_tick_i | input | 1 | Millisecond tick pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with DW=16 and PW=8. A narrow data path lets a few heavy-weight events hit accumulator saturation, and a narrow period field keeps every period sweep short. It sweeps K over 0..3 against several event counts and seeds, run lengths N over 1..4 in both directions, and tick periods over 1..3. It computes each expected average from the update formula. The small widths put every boundary within a few hundred cycles: the last non-firing period, a broken run, and the carry of an event that arrives in the closing cycle.

// File: rtl/act_mon_pkg.sv
package act_mon_pkg;
  localparam logic [7:0] OFF_CTRL   = 8'h00;
  localparam logic [7:0] OFF_WM_HI  = 8'h04;
  localparam logic [7:0] OFF_WM_LO  = 8'h08;
  localparam logic [7:0] OFF_SEED   = 8'h0C;
  localparam logic [7:0] OFF_AV_HI  = 8'h10;
  localparam logic [7:0] OFF_AV_LO  = 8'h14;
  localparam logic [7:0] OFF_WEIGHT = 8'h18;
  localparam logic [7:0] OFF_AVG    = 8'h20;
  localparam logic [7:0] OFF_STATUS = 8'h24;
  localparam logic [7:0] OFF_PERIOD = 8'h40;

  localparam int B_EN      = 31;
  localparam int B_RUN_UP  = 30;
  localparam int B_RUN_DN  = 29;
  localparam int F_UP_N    = 26;
  localparam int F_DN_N    = 23;
  localparam int B_AVG_UP  = 21;
  localparam int B_AVG_DN  = 20;
  localparam int B_PERIOD  = 18;
  localparam int F_K       = 10;
  localparam int RUN_W     = 3;
  localparam int K_W       = 3;
  localparam logic [31:0] CTRL_MASK = 32'hFFB4_1C00;
endpackage

// File: rtl/act_period_gen.sv
module act_period_gen #(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          ms_tick_i,
  input  logic [PW-1:0] period_i,
  output logic          close_o
);
  logic [PW-1:0] cnt_q;
  logic          last;

  // >= so a period lowered mid-count still wraps promptly
  assign last    = (cnt_q >= period_i);
  assign close_o = run_i & ms_tick_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (ms_tick_i)      cnt_q <= last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/act_accum_avg.sv
module act_accum_avg #(
  parameter int DW  = 32,
  parameter int K_W = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clear_i,
  input  logic           evt_i,
  input  logic [DW-1:0]  weight_i,
  input  logic           close_i,
  input  logic [K_W-1:0] k_i,
  input  logic           seed_we_i,
  input  logic [DW-1:0]  seed_i,
  output logic [DW-1:0]  sample_o,
  output logic [DW-1:0]  avg_o,
  output logic [DW-1:0]  avg_nx_o
);
  logic [DW-1:0]        acc_q, avg_q;
  logic [DW:0]          acc_sum;
  logic [DW-1:0]        acc_sat;
  logic signed [DW+1:0] diff, step, upd;
  logic [K_W:0]         shamt;

  assign acc_sum = {1'b0, acc_q} + {1'b0, weight_i};
  assign acc_sat = acc_sum[DW] ? '1 : acc_sum[DW-1:0];

  assign shamt = {1'b0, k_i} + 1'b1;
  assign diff  = $signed({2'b00, acc_q}) - $signed({2'b00, avg_q});
  assign step  = diff >>> shamt;
  assign upd   = $signed({2'b00, avg_q}) + step;

  assign sample_o = acc_q;
  assign avg_o    = avg_q;
  assign avg_nx_o = upd[DW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (close_i) acc_q <= evt_i ? weight_i : '0;
    else if (evt_i)   acc_q <= acc_sat;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        avg_q <= '0;
    else if (seed_we_i) avg_q <= seed_i;
    else if (close_i)   avg_q <= avg_nx_o;
  end
endmodule

// File: rtl/act_run_cnt.sv
module act_run_cnt #(
  parameter int RW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          close_i,
  input  logic          breach_i,
  input  logic [RW-1:0] run_i,
  output logic          fire_o
);
  logic [RW-1:0] cnt_q;
  logic          hit;

  assign hit    = (cnt_q >= run_i);
  assign fire_o = close_i & breach_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (close_i)  cnt_q <= (breach_i && !hit) ? cnt_q + 1'b1 : '0;
  end
endmodule

// File: rtl/act_mon.sv
module act_mon
  import act_mon_pkg::*;
#(
  parameter int DW = 32,
  parameter int PW = 8,
  parameter int AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          evt_i,
  input  logic          ms_tick_i,
  output logic          irq_o
);
  localparam int NDIR = 2;

  logic [31:0]   ctrl_q;
  logic [DW-1:0] wm_hi_q, wm_lo_q, av_hi_q, av_lo_q, weight_q;
  logic [PW-1:0] period_q;
  logic [3:0]    status_q, st_set, st_clr, st_en;

  logic en, close, seed_we;
  logic [DW-1:0] sample, avg, avg_nx;
  logic [NDIR-1:0] breach, fire;
  logic [NDIR-1:0][RUN_W-1:0] run_n;

  function automatic logic sel(input logic [AW-1:0] a, input logic [7:0] off);
    return a == AW'(off);
  endfunction

  assign en      = ctrl_q[B_EN];
  assign seed_we = reg_we_i & sel(reg_addr_i, OFF_SEED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      wm_hi_q  <= '0;
      wm_lo_q  <= '0;
      av_hi_q  <= '0;
      av_lo_q  <= '0;
      weight_q <= '0;
      period_q <= '0;
    end else if (reg_we_i) begin
      if (sel(reg_addr_i, OFF_CTRL))   ctrl_q   <= reg_wdata_i & CTRL_MASK;
      if (sel(reg_addr_i, OFF_WM_HI))  wm_hi_q  <= reg_wdata_i[DW-1:0];
      if (sel(reg_addr_i, OFF_WM_LO))  wm_lo_q  <= reg_wdata_i[DW-1:0];
      if (sel(reg_addr_i, OFF_AV_HI))  av_hi_q  <= reg_wdata_i[DW-1:0];
      if (sel(reg_addr_i, OFF_AV_LO))  av_lo_q  <= reg_wdata_i[DW-1:0];
      if (sel(reg_addr_i, OFF_WEIGHT)) weight_q <= reg_wdata_i[DW-1:0];
      if (sel(reg_addr_i, OFF_PERIOD)) period_q <= reg_wdata_i[PW-1:0];
    end
  end

  act_period_gen #(.PW(PW)) u_period (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (en & ctrl_q[B_PERIOD]),
    .ms_tick_i (ms_tick_i),
    .period_i  (period_q),
    .close_o   (close)
  );

  act_accum_avg #(.DW(DW), .K_W(K_W)) u_avg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (!en),
    .evt_i     (evt_i),
    .weight_i  (weight_q),
    .close_i   (close),
    .k_i       (ctrl_q[F_K +: K_W]),
    .seed_we_i (seed_we),
    .seed_i    (reg_wdata_i[DW-1:0]),
    .sample_o  (sample),
    .avg_o     (avg),
    .avg_nx_o  (avg_nx)
  );

  assign breach[0] = sample > wm_hi_q;
  assign breach[1] = sample < wm_lo_q;
  assign run_n[0]  = ctrl_q[F_UP_N +: RUN_W];
  assign run_n[1]  = ctrl_q[F_DN_N +: RUN_W];

  for (genvar g = 0; g < NDIR; g++) begin : g_run
    act_run_cnt #(.RW(RUN_W)) u_run (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clear_i  (!en),
      .close_i  (close),
      .breach_i (breach[g]),
      .run_i    (run_n[g]),
      .fire_o   (fire[g])
    );
  end

  assign st_en  = {ctrl_q[B_RUN_UP], ctrl_q[B_RUN_DN], ctrl_q[B_AVG_UP], ctrl_q[B_AVG_DN]};
  assign st_set = {fire[0], fire[1], close & (avg_nx > av_hi_q), close & (avg_nx < av_lo_q)} & st_en;
  assign st_clr = (reg_we_i && sel(reg_addr_i, OFF_STATUS)) ? reg_wdata_i[31:28] : 4'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~st_clr) | st_set;
  end

  assign irq_o = en & |(status_q & st_en);

  always_comb begin
    reg_rdata_o = '0;
    if (sel(reg_addr_i, OFF_CTRL))   reg_rdata_o = ctrl_q;
    if (sel(reg_addr_i, OFF_WM_HI))  reg_rdata_o = 32'(wm_hi_q);
    if (sel(reg_addr_i, OFF_WM_LO))  reg_rdata_o = 32'(wm_lo_q);
    if (sel(reg_addr_i, OFF_SEED))   reg_rdata_o = 32'(avg);
    if (sel(reg_addr_i, OFF_AV_HI))  reg_rdata_o = 32'(av_hi_q);
    if (sel(reg_addr_i, OFF_AV_LO))  reg_rdata_o = 32'(av_lo_q);
    if (sel(reg_addr_i, OFF_WEIGHT)) reg_rdata_o = 32'(weight_q);
    if (sel(reg_addr_i, OFF_AVG))    reg_rdata_o = 32'(avg);
    if (sel(reg_addr_i, OFF_STATUS)) reg_rdata_o = {status_q, 28'b0};
    if (sel(reg_addr_i, OFF_PERIOD)) reg_rdata_o = 32'(period_q);
  end
endmodule

// File: rtl/act_mon_chk.sv
module act_mon_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en,
  input logic          close,
  input logic          seed_we,
  input logic          evt_i,
  input logic          irq_o,
  input logic [3:0]    status_q,
  input logic [1:0]    breach,
  input logic [DW-1:0] sample,
  input logic [DW-1:0] avg
);
  assert_irq_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !irq_o);

  assert_avg_moves_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(avg) |-> $past(close || seed_we));

  assert_acc_grows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && !close && evt_i) |=> sample >= $past(sample));

  assert_acc_cleared_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> sample == '0);

  assert_up_needs_breach_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_q[3]) |-> $past(close && breach[0]));

  assert_dn_needs_breach_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_q[2]) |-> $past(close && breach[1]));

  assert_avg_flag_on_close_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(status_q[1]) || $rose(status_q[0])) |-> $past(close));
endmodule

bind act_mon act_mon_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en       (en),
  .close    (close),
  .seed_we  (seed_we),
  .evt_i    (evt_i),
  .irq_o    (irq_o),
  .status_q (status_q),
  .breach   (breach),
  .sample   (sample),
  .avg      (avg)
);

// File: tb/tb_act_mon.sv
`timescale 1ns/1ps
module tb_act_mon;
  localparam int DW = 16;
  localparam int PW = 8;
  localparam int AW = 7;
  localparam logic [31:0] EN = 32'h8000_0000, RUP = 32'h4000_0000, RDN = 32'h2000_0000;
  localparam logic [31:0] AUP = 32'h0020_0000, ADN = 32'h0010_0000, PER = 32'h0004_0000;

  logic clk = 0, rst_ni = 0;
  logic we = 0, evt = 0, ms = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  act_mon #(.DW(DW), .PW(PW), .AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_i(evt),
    .ms_tick_i(ms), .irq_o(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a[AW-1:0]; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a[AW-1:0]; #1; d = rdata;
  endtask

  task automatic tick();
    @(negedge clk); ms = 1;
    @(negedge clk); ms = 0;
  endtask

  task automatic evts(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evt = 1;
      @(negedge clk); evt = 0;
    end
  endtask

  function automatic longint ema(input longint a, input longint s, input int k);
    longint d = s - a;
    return a + (d >>> (k + 1));
  endfunction

  task automatic restart(input logic [31:0] c);
    wr(8'h00, 32'h0);
    wr(8'h24, 32'hF000_0000);
    wr(8'h00, c);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R1 reset state
    rd(8'h00, v); check("R1 ctrl reset", v, 0);
    rd(8'h24, v); check("R1 status reset", v, 0);
    rd(8'h20, v); check("R1 avg reset", v, 0);
    rd(8'h18, v); check("R1 weight reset", v, 0);
    check("R1 irq reset", {31'b0, irq}, 0);
    // R1 readback
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, v); check("R1 ctrl mask", v, 32'hFFB4_1C00);
    wr(8'h00, 0);
    wr(8'h04, 32'h1234); rd(8'h04, v); check("R1 hi", v, 32'h1234);
    wr(8'h08, 32'h0567); rd(8'h08, v); check("R1 lo", v, 32'h0567);
    wr(8'h10, 32'h0aaa); rd(8'h10, v); check("R1 avg hi", v, 32'h0aaa);
    wr(8'h14, 32'h0bbb); rd(8'h14, v); check("R1 avg lo", v, 32'h0bbb);
    wr(8'h40, 32'h3);    rd(8'h40, v); check("R1 period", v, 32'h3);
    wr(8'h04, 0); wr(8'h08, 0); wr(8'h10, 32'hFFFF); wr(8'h14, 0);
    wr(8'h40, 0);

    // R4 R5 EMA sweep
    wr(8'h18, 37);
    for (int k = 0; k < 4; k++) begin
      for (int e = 0; e < 4; e++) begin
        int n = e * e + e;
        longint exp_avg;
        restart(EN | PER | (k << 10));
        wr(8'h0C, 200);
        rd(8'h20, v); check("R5 seed", v, 200);
        evts(n); tick();
        exp_avg = ema(200, n * 37, k);
        rd(8'h20, v); check("R4 ema", v, 32'(exp_avg));
        rd(8'h0C, v); check("R5 alias", v, 32'(exp_avg));
      end
    end

    // R2 period length
    for (int p = 1; p < 4; p++) begin
      wr(8'h40, p);
      restart(EN | PER);
      wr(8'h0C, 0);
      evts(4);
      for (int t = 0; t < p; t++) tick();
      rd(8'h20, v); check("R2 not yet", v, 0);
      tick();
      rd(8'h20, v); check("R2 closed", v, 74);
    end
    wr(8'h40, 0);
    restart(EN);
    wr(8'h0C, 0);
    evts(4); tick(); tick(); tick();
    rd(8'h20, v); check("R2 periodic off", v, 0);

    // R3 saturation and closing-cycle carry
    wr(8'h18, 32'h8000);
    restart(EN | PER);
    wr(8'h0C, 0);
    evts(3); tick();
    rd(8'h20, v); check("R3 saturate", v, 32767);
    wr(8'h18, 10);
    restart(EN | PER);
    wr(8'h0C, 0);
    evts(2);
    @(negedge clk); ms = 1; evt = 1;
    @(negedge clk); ms = 0; evt = 0;
    rd(8'h20, v); check("R3 first close", v, 10);
    tick();
    rd(8'h20, v); check("R3 carry", v, 10);

    // R6 consecutive above, N=1..4
    wr(8'h18, 20); wr(8'h04, 10); wr(8'h08, 0);
    for (int n = 1; n < 5; n++) begin
      restart(EN | PER | RUP | ((n - 1) << 26));
      for (int i = 0; i < n - 1; i++) begin evts(1); tick(); end
      rd(8'h24, v); check("R6 before run", v, 0);
      evts(1); tick();
      rd(8'h24, v); check("R6 run done", v, 32'h8000_0000);
      check("R10 irq up", {31'b0, irq}, 1);
      wr(8'h24, 32'h8000_0000);
      rd(8'h24, v); check("R9 cleared", v, 0);
      check("R10 irq low", {31'b0, irq}, 0);
    end
    // R6 broken run
    restart(EN | PER | RUP | (2 << 26));
    evts(1); tick(); evts(1); tick(); tick();
    evts(1); tick(); evts(1); tick();
    rd(8'h24, v); check("R6 broken", v, 0);
    evts(1); tick();
    rd(8'h24, v); check("R6 after broken", v, 32'h8000_0000);
    // R6 restart after firing
    restart(EN | PER | RUP | (1 << 26));
    evts(1); tick(); evts(1); tick();
    wr(8'h24, 32'h8000_0000);
    evts(1); tick();
    rd(8'h24, v); check("R6 restart after fire", v, 0);
    evts(1); tick();
    rd(8'h24, v); check("R6 refire", v, 32'h8000_0000);
    // R6 disabled enable bit
    restart(EN | PER);
    evts(1); tick();
    rd(8'h24, v); check("R6 enable off", v, 0);

    // R7 consecutive below, N=1..4
    wr(8'h04, 32'hFFFF); wr(8'h08, 10);
    for (int n = 1; n < 5; n++) begin
      restart(EN | PER | RDN | ((n - 1) << 23));
      for (int i = 0; i < n - 1; i++) tick();
      rd(8'h24, v); check("R7 before run", v, 0);
      tick();
      rd(8'h24, v); check("R7 run done", v, 32'h4000_0000);
      check("R10 irq dn", {31'b0, irq}, 1);
    end

    // R8 average watermarks
    wr(8'h08, 0); wr(8'h18, 10); wr(8'h10, 100); wr(8'h14, 50);
    restart(EN | PER | AUP | ADN);
    wr(8'h0C, 80); tick();
    rd(8'h24, v); check("R8 below", v, 32'h1000_0000);
    wr(8'h24, 32'h1000_0000);
    wr(8'h0C, 80); evts(20); tick();
    rd(8'h24, v); check("R8 above", v, 32'h2000_0000);
    // R9 partial clear
    wr(8'h24, 32'h1000_0000);
    rd(8'h24, v); check("R9 other kept", v, 32'h2000_0000);
    // R10 R11 gating
    check("R10 irq avg", {31'b0, irq}, 1);
    wr(8'h00, AUP | ADN | PER);
    check("R11 irq off", {31'b0, irq}, 0);
    rd(8'h24, v); check("R11 status kept", v, 32'h2000_0000);
    wr(8'h00, EN | AUP | ADN | PER);
    check("R10 irq back", {31'b0, irq}, 1);
    restart(EN | PER);
    wr(8'h0C, 80); evts(20); tick();
    rd(8'h24, v); check("R8 enables off", v, 0);
    // R11 accumulator cleared by disable
    restart(EN | PER);
    wr(8'h0C, 100); evts(5);
    wr(8'h00, PER); wr(8'h00, EN | PER);
    tick();
    rd(8'h20, v); check("R11 acc cleared", v, 50);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule